// File: doc/BRIEF.md
# Single-Precision Float to Fixed-Point Converter

This block turns a single-precision floating-point word into a 16-bit or 32-bit integer, signed or unsigned. The integer can carry a chosen number of fraction bits: the float is multiplied by two to the power of a fraction count, rounded to an integer, and clamped to the range of the chosen target format. Two status flags come out with the result. One marks an invalid conversion, which covers a NaN input and any clamped result. The other marks an inexact conversion, where rounding dropped a nonzero fraction.

The block is a single pipeline stage. The inputs are sampled on a rising clock edge, and the result and flags appear on the registered outputs after that edge. Rounding either truncates toward zero, when the truncate select is set, or follows a 2-bit mode field. A 16-bit result is widened to the 32-bit output port: sign-extended for signed targets and zero-extended for unsigned ones.

Top module: `fx_cvt`

## Requirements
- R1: While reset is asserted, `res_o`, `inv_o` and `inx_o` are all zero.
- R2: The outputs show the conversion of the inputs sampled at the previous rising edge. The converted quantity is the float value times 2^`fbits_i`, where `fbits_i` runs from 0 to 32.
- R3: When `trunc_i`=1 the quantity is rounded toward zero. Otherwise `rmode_i` selects the rounding: 0 is nearest with ties to even, 1 is toward +infinity, 2 is toward -infinity, 3 is toward zero.
- R4: `inx_o`=1 exactly when the rounded integer differs from the scaled quantity and no clamping took place.
- R5: A NaN input (exponent all ones, nonzero fraction) gives `res_o`=0, `inv_o`=1 and `inx_o`=0.
- R6: Signed targets (`sgn_i`=1) clamp to -32768..32767 when `half_i`=1 and to -2^31..2^31-1 when `half_i`=0. A value exactly at a bound is not clamped.
- R7: Unsigned targets (`sgn_i`=0) clamp a negative rounded value to 0 and an oversize one to 0xFFFF (`half_i`=1) or 0xFFFFFFFF (`half_i`=0). A negative input that rounds to zero is not clamped.
- R8: Any clamp, including one caused by an infinite input, sets `inv_o`=1 and forces `inx_o`=0.
- R9: With `half_i`=1, `res_o[31:16]` repeats `res_o[15]` for signed targets and is zero for unsigned targets.
- R10: `inv_o` and `inx_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flt_i | input | 32 | Single-precision input word |
| sgn_i | input | 1 | 1: signed target, 0: unsigned target |
| half_i | input | 1 | 1: 16-bit target, 0: 32-bit target |
| fbits_i | input | 6 | Fraction-bit count (scale exponent), 0..32 |
| trunc_i | input | 1 | 1: force rounding toward zero |
| rmode_i | input | 2 | Rounding mode when `trunc_i`=0 |
| res_o | output | 32 | Extended fixed-point result |
| inv_o | output | 1 | Invalid flag |
| inx_o | output | 1 | Inexact flag |

## Verification
Rounding and clamping can meet in one conversion. A fraction that rounds the magnitude up by one can push it past a bound, for example a 16-bit unsigned value just below 65536 rounded toward +infinity, or a negative fraction rounded toward -infinity for an unsigned target. Directed cases place values at, just inside and just past each bound under different rounding modes. In those cases the bench expects the clamped value with only the invalid flag set. Random stimulus then sweeps exponents around the point where the scaled value crosses the target range, and checks every result against a separate model that compares remainders.

// File: rtl/fx_pkg.sv
package fx_pkg;
  localparam int EXP_W   = 8;
  localparam int MAN_W   = 23;
  localparam int FLT_W   = EXP_W + MAN_W + 1;
  localparam int SIG_W   = MAN_W + 1;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int OUT_W   = 32;
  localparam int HALF_W  = 16;
  localparam int IMM_W   = 6;
  localparam int SH_W    = EXP_W + 4;
  // left shifts at or above this limit push any nonzero significand out of range
  localparam int SHL_LIM = OUT_W - SIG_W + 1;
  // right shifts beyond this cap leave only sticky information
  localparam int SHR_CAP = SIG_W + 2;
  localparam int MAG_W   = OUT_W + 2;

  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_POS  = 2'd1,
    RND_NEG  = 2'd2,
    RND_TRNC = 2'd3
  } rnd_e;

  typedef struct packed {
    logic                    sign;
    logic                    is_nan;
    logic                    is_inf;
    logic [SIG_W-1:0]        sig;
    logic signed [SH_W-1:0]  scl;   // exponent of the significand's LSB
  } fp_fields_t;
endpackage

// File: rtl/fx_unpack.sv
module fx_unpack
  import fx_pkg::*;
(
  input  logic [FLT_W-1:0] flt_i,
  output fp_fields_t       fld_o
);
  logic [EXP_W-1:0] exp_raw;
  logic [MAN_W-1:0] man_raw;
  logic             exp_max;
  logic             exp_min;

  always_comb begin
    exp_raw = flt_i[FLT_W-2 -: EXP_W];
    man_raw = flt_i[MAN_W-1:0];
    exp_max = &exp_raw;
    exp_min = ~|exp_raw;

    fld_o.sign   = flt_i[FLT_W-1];
    fld_o.is_nan = exp_max & (|man_raw);
    fld_o.is_inf = exp_max & ~(|man_raw);
    fld_o.sig    = {~exp_min, man_raw};
    // subnormals use the minimum exponent with no hidden bit
    fld_o.scl    = SH_W'(exp_min ? 1 : int'(exp_raw)) - SH_W'(BIAS + MAN_W);
  end
endmodule

// File: rtl/fx_align_round.sv
module fx_align_round
  import fx_pkg::*;
(
  input  fp_fields_t        fld_i,
  input  logic [IMM_W-1:0]  fbits_i,
  input  rnd_e              rnd_i,
  output logic [MAG_W-1:0]  mag_o,
  output logic              huge_o,
  output logic              frac_o
);
  localparam int WIDE_W = SIG_W + SHR_CAP;

  logic signed [SH_W-1:0] sh;
  logic [SH_W-1:0]        rsh;
  logic [WIDE_W-1:0]      wide;
  logic [SIG_W-1:0]       ipart;
  logic                   guard;
  logic                   sticky;
  logic                   bump;

  always_comb begin
    sh     = fld_i.scl + SH_W'(fbits_i);
    rsh    = '0;
    wide   = '0;
    ipart  = '0;
    guard  = 1'b0;
    sticky = 1'b0;
    bump   = 1'b0;
    mag_o  = '0;
    huge_o = 1'b0;
    frac_o = 1'b0;

    if (sh >= 0) begin
      if (sh >= SH_W'(SHL_LIM)) huge_o = |fld_i.sig;
      else                      mag_o  = MAG_W'(fld_i.sig) << sh;
    end else begin
      rsh    = (-sh > SH_W'(SHR_CAP)) ? SH_W'(SHR_CAP) : SH_W'(-sh);
      wide   = {fld_i.sig, {SHR_CAP{1'b0}}} >> rsh;
      ipart  = wide[WIDE_W-1 -: SIG_W];
      guard  = wide[SHR_CAP-1];
      sticky = |wide[SHR_CAP-2:0];
      frac_o = guard | sticky;
      unique case (rnd_i)
        RND_NEAR: bump = guard & (sticky | ipart[0]);
        RND_POS:  bump = frac_o & ~fld_i.sign;
        RND_NEG:  bump = frac_o & fld_i.sign;
        default:  bump = 1'b0;
      endcase
      mag_o = MAG_W'(ipart) + MAG_W'(bump);
    end
  end
endmodule

// File: rtl/fx_saturate.sv
module fx_saturate
  import fx_pkg::*;
(
  input  logic             sign_i,
  input  logic             nan_i,
  input  logic             big_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             frac_i,
  input  logic             sgn_i,
  input  logic             half_i,
  output logic [OUT_W-1:0] res_o,
  output logic             inv_o,
  output logic             inx_o
);
  logic [MAG_W-1:0] pos_lim;
  logic [MAG_W-1:0] neg_lim;
  logic [MAG_W-1:0] raw;
  logic             neg;

  always_comb begin
    unique case ({sgn_i, half_i})
      2'b11:   pos_lim = MAG_W'((64'd1 << (HALF_W - 1)) - 1);
      2'b01:   pos_lim = MAG_W'((64'd1 << HALF_W) - 1);
      2'b10:   pos_lim = MAG_W'((64'd1 << (OUT_W - 1)) - 1);
      default: pos_lim = MAG_W'((64'd1 << OUT_W) - 1);
    endcase
    neg_lim = half_i ? MAG_W'(64'd1 << (HALF_W - 1)) : MAG_W'(64'd1 << (OUT_W - 1));
    neg     = sign_i & (big_i | (|mag_i));
    raw     = '0;
    inv_o   = 1'b0;

    if (nan_i) begin
      inv_o = 1'b1;
    end else if (neg) begin
      if (!sgn_i) begin
        inv_o = 1'b1;
      end else if (big_i || mag_i > neg_lim) begin
        raw   = -neg_lim;
        inv_o = 1'b1;
      end else begin
        raw = -mag_i;
      end
    end else if (big_i || mag_i > pos_lim) begin
      raw   = pos_lim;
      inv_o = 1'b1;
    end else begin
      raw = mag_i;
    end

    inx_o = frac_i & ~inv_o & ~nan_i;
  end

  // narrow targets are widened to the port width by signedness
  generate
    if (OUT_W > HALF_W) begin : g_ext
      always_comb begin
        if (half_i)
          res_o = {{(OUT_W-HALF_W){sgn_i & raw[HALF_W-1]}}, raw[HALF_W-1:0]};
        else
          res_o = raw[OUT_W-1:0];
      end
    end else begin : g_noext
      always_comb res_o = raw[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/fx_cvt.sv
module fx_cvt
  import fx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      flt_i,
  input  logic             sgn_i,
  input  logic             half_i,
  input  logic [5:0]       fbits_i,
  input  logic             trunc_i,
  input  logic [1:0]       rmode_i,
  output logic [31:0]      res_o,
  output logic             inv_o,
  output logic             inx_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  fp_fields_t       fld;
  rnd_e             rnd_eff;
  logic [MAG_W-1:0] mag;
  logic             huge;
  logic             frac;
  logic [OUT_W-1:0] res_d;
  logic             inv_d;
  logic             inx_d;
  logic             cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign rnd_eff = trunc_i ? RND_TRNC : rnd_e'(rmode_i);
  assign cap_en  = 1'b1;

  fx_unpack u_unpack (
    .flt_i (flt_i),
    .fld_o (fld)
  );

  fx_align_round u_align (
    .fld_i   (fld),
    .fbits_i (fbits_i),
    .rnd_i   (rnd_eff),
    .mag_o   (mag),
    .huge_o  (huge),
    .frac_o  (frac)
  );

  fx_saturate u_sat (
    .sign_i (fld.sign),
    .nan_i  (fld.is_nan),
    .big_i  (huge | fld.is_inf),
    .mag_i  (mag),
    .frac_i (frac),
    .sgn_i  (sgn_i),
    .half_i (half_i),
    .res_o  (res_d),
    .inv_o  (inv_d),
    .inx_o  (inx_d)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_o <= '0;
      inv_o <= 1'b0;
      inx_o <= 1'b0;
    end else if (cap_en) begin
      res_o <= res_d;
      inv_o <= inv_d;
      inx_o <= inx_d;
    end
  end
endmodule

// File: rtl/fx_cvt_chk.sv
module fx_cvt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] flt_i,
  input logic        sgn_i,
  input logic        half_i,
  input logic [31:0] res_o,
  input logic        inv_o,
  input logic        inx_o
);
  logic [1:0] up_cnt;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              up_cnt <= 2'd0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end
  assign armed = (up_cnt == 2'd3);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (res_o == 32'd0 && !inv_o && !inx_o);
    end
  end

  // R10
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !(inv_o && inx_o));

  // R5
  nan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(flt_i[30:23]) == 8'hFF && $past(flt_i[22:0]) != 23'd0)
      |-> (res_o == 32'd0 && inv_o && !inx_o));

  // R9
  half_signext_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(half_i) && $past(sgn_i)) |-> (res_o[31:16] == {16{res_o[15]}}));

  // R9
  half_zeroext_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(half_i) && !$past(sgn_i)) |-> (res_o[31:16] == 16'd0));

  // R7
  unsigned_neg_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (!$past(sgn_i) && $past(flt_i[31]) && inv_o) |-> (res_o == 32'd0));

  // R6
  signed_pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(sgn_i) && !$past(flt_i[31]) && $past(flt_i[30:23]) != 8'hFF && inv_o)
      |-> (res_o == ($past(half_i) ? 32'h0000_7FFF : 32'h7FFF_FFFF)));
endmodule

bind fx_cvt fx_cvt_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .flt_i  (flt_i),
  .sgn_i  (sgn_i),
  .half_i (half_i),
  .res_o  (res_o),
  .inv_o  (inv_o),
  .inx_o  (inx_o)
);

// File: tb/fx_cvt_tb.sv
module fx_cvt_tb;
  logic        clk;
  logic        rst_n;
  logic [31:0] flt_i;
  logic        sgn_i;
  logic        half_i;
  logic [5:0]  fbits_i;
  logic        trunc_i;
  logic [1:0]  rmode_i;
  logic [31:0] res_o;
  logic        inv_o;
  logic        inx_o;

  int n_chk;
  int n_bad;
  bit done;

  fx_cvt u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .flt_i   (flt_i),
    .sgn_i   (sgn_i),
    .half_i  (half_i),
    .fbits_i (fbits_i),
    .trunc_i (trunc_i),
    .rmode_i (rmode_i),
    .res_o   (res_o),
    .inv_o   (inv_o),
    .inx_o   (inx_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // independent model: integer part plus remainder compared against one half
  function automatic logic [33:0] model(input logic [31:0] f, input bit sg, input bit hf,
                                        input int fb, input bit tr, input int rm);
    bit s;
    int e;
    int sh;
    int k;
    int mode;
    longint unsigned m;
    longint unsigned ip;
    longint unsigned rem;
    longint unsigned hlf;
    longint v;
    longint lo;
    longint hi;
    bit big;
    bit inv;
    bit inx;
    bit up;
    int cmp;
    s    = f[31];
    e    = int'(f[30:23]);
    m    = {40'd0, (e != 0), f[22:0]};
    mode = tr ? 3 : rm;
    big  = 0; inv = 0; ip = 0; rem = 0; cmp = 0; up = 0;
    if (hf) begin lo = sg ? -32768 : 0; hi = sg ? 32767 : 65535; end
    else    begin lo = sg ? -64'sd2147483648 : 0; hi = sg ? 64'sd2147483647 : 64'sd4294967295; end
    if (e == 255 && f[22:0] != 0) return {32'd0, 1'b1, 1'b0};
    if (e == 255) big = 1;
    else begin
      sh = ((e == 0) ? 1 : e) - 150 + fb;
      if (m == 0) ip = 0;
      else if (sh >= 20) big = 1;
      else if (sh >= 0) ip = m << sh;
      else begin
        k = -sh;
        if (k >= 60) begin ip = 0; rem = 1; cmp = -1; end
        else begin
          ip  = m >> k;
          rem = m - (ip << k);
          hlf = 64'd1 << (k - 1);
          cmp = (rem < hlf) ? -1 : ((rem == hlf) ? 0 : 1);
        end
      end
    end
    if (!big && rem != 0) begin
      case (mode)
        0: up = (cmp > 0) || (cmp == 0 && ip[0]);
        1: up = !s;
        2: up = s;
        default: up = 0;
      endcase
      if (up) ip = ip + 1;
    end
    if (big) begin v = s ? lo : hi; inv = 1; end
    else begin
      v = s ? -longint'(ip) : longint'(ip);
      if (v < lo) begin v = lo; inv = 1; end
      else if (v > hi) begin v = hi; inv = 1; end
    end
    inx = (rem != 0) && !inv;
    return {v[31:0], inv, inx};
  endfunction

  task automatic check(input string tag, input logic [31:0] er, input bit ei, input bit ex);
    n_chk++;
    if (res_o !== er || inv_o !== ei || inx_o !== ex || (inv_o && inx_o)) begin
      n_bad++;
      $display("FAIL %s: res=%h inv=%b inx=%b expected res=%h inv=%b inx=%b",
               tag, res_o, inv_o, inx_o, er, ei, ex);
    end
  endtask

  task automatic apply(input logic [31:0] f, input bit sg, input bit hf, input int fb,
                       input bit tr, input int rm);
    @(negedge clk);
    flt_i = f; sgn_i = sg; half_i = hf; fbits_i = 6'(fb); trunc_i = tr; rmode_i = 2'(rm);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic directed(input string tag, input logic [31:0] f, input bit sg, input bit hf,
                          input int fb, input bit tr, input int rm,
                          input logic [31:0] er, input bit ei, input bit ex);
    apply(f, sg, hf, fb, tr, rm);
    check(tag, er, ei, ex);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: res=%h inv=%b inx=%b expected completion", res_o, inv_o, inx_o);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [33:0] exp_v;
    logic [31:0] f;
    bit sg;
    bit hf;
    bit tr;
    int fb;
    int rm;
    n_chk = 0; n_bad = 0; done = 0;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    flt_i = 32'h3FC0_0000; sgn_i = 1; half_i = 0; fbits_i = 0; trunc_i = 0; rmode_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", 32'd0, 0, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    directed("R3 tie 0.5 to even",      32'h3F00_0000, 1, 0, 0, 0, 0, 32'd0, 0, 1);
    directed("R3 tie 1.5 to even",      32'h3FC0_0000, 1, 0, 0, 0, 0, 32'd2, 0, 1);
    directed("R3 tie 2.5 to even",      32'h4020_0000, 1, 0, 0, 0, 0, 32'd2, 0, 1);
    directed("R3 truncate select",      32'h3FC0_0000, 1, 0, 0, 1, 0, 32'd1, 0, 1);
    directed("R3 toward +inf neg",      32'hBFC0_0000, 1, 0, 0, 0, 1, 32'hFFFF_FFFF, 0, 1);
    directed("R3 toward -inf neg",      32'hBFC0_0000, 1, 0, 0, 0, 2, 32'hFFFF_FFFE, 0, 1);
    directed("R2 scale 1.25 by 4",      32'h3FA0_0000, 1, 0, 2, 0, 0, 32'd5, 0, 0);
    directed("R5 quiet NaN",            32'h7FC0_0000, 1, 0, 0, 0, 1, 32'd0, 1, 0);
    directed("R5 signalling NaN",       32'hFF80_0001, 0, 1, 5, 0, 0, 32'd0, 1, 0);
    directed("R8 +inf signed half",     32'h7F80_0000, 1, 1, 0, 0, 0, 32'h0000_7FFF, 1, 0);
    directed("R8 -inf unsigned",        32'hFF80_0000, 0, 0, 0, 0, 0, 32'd0, 1, 0);
    directed("R9 -inf signed half",     32'hFF80_0000, 1, 1, 0, 0, 0, 32'hFFFF_8000, 1, 0);
    directed("R6 2^31 signed",          32'h4F00_0000, 1, 0, 0, 0, 0, 32'h7FFF_FFFF, 1, 0);
    directed("R6 -2^31 exact bound",    32'hCF00_0000, 1, 0, 0, 0, 0, 32'h8000_0000, 0, 0);
    directed("R6 -40000 signed half",   32'hC71C_4000, 1, 1, 0, 0, 0, 32'hFFFF_8000, 1, 0);
    directed("R7 65535.5 trunc half",   32'h477F_FF80, 0, 1, 0, 1, 0, 32'h0000_FFFF, 0, 1);
    directed("R8 65535.5 up to 65536",  32'h477F_FF80, 0, 1, 0, 0, 1, 32'h0000_FFFF, 1, 0);
    directed("R7 65536 unsigned half",  32'h4780_0000, 0, 1, 0, 0, 0, 32'h0000_FFFF, 1, 0);
    directed("R7 -0.25 trunc unsigned", 32'hBE80_0000, 0, 0, 0, 1, 0, 32'd0, 0, 1);
    directed("R7 -0.25 down unsigned",  32'hBE80_0000, 0, 0, 0, 0, 2, 32'd0, 1, 0);
    directed("R4 subnormal up",         32'h0000_0001, 1, 0, 32, 0, 1, 32'd1, 0, 1);
    directed("R9 -2 signed half",       32'hC000_0000, 1, 1, 0, 0, 0, 32'hFFFF_FFFE, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      f = $urandom;
      if ($urandom % 8 != 0) f[30:23] = 8'(100 + $urandom % 70);
      if ($urandom % 4 == 0) f[15:0] = 16'd0;
      sg = 1'($urandom); hf = 1'($urandom); tr = ($urandom % 4 == 0);
      fb = $urandom % 33; rm = $urandom % 4;
      exp_v = model(f, sg, hf, fb, tr, rm);
      apply(f, sg, hf, fb, tr, rm);
      check("R2 random", exp_v[33:2], exp_v[1], exp_v[0]);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule